// File: doc/BRIEF.md
# Dual-Tap Line Delay Memory

This block stores scan lines of pixels for an image pipeline and gives back two delayed copies of the picture at once. Each accepted write places one pixel into a first line bank at the current write position. The pixel that bank held at that position moves into a second bank at the same position. A read at a given position therefore returns two values on the same edge. The first tap is the most recent pixel stored there, which is one line behind the line being written. The second tap is the pixel before that, which is two lines behind. Filters that work across neighbouring lines, such as vertical smoothing or error correction, can then see three consecutive lines at the same column.

The write side and the read side each have their own clock, enable and pointer clear, and the two sides run without any fixed relation. A producer and a consumer with different throughput can share the buffer. A pulse on a port's clear input at the start of each line aligns that port's position counter to column zero. Both position counters also wrap by themselves after the last column. The read data pins are three-state. They are driven only after a read edge and float otherwise, so several line stores can share one bus.

Top module: `ldm_line_delay`

## Requirements
- R1: A write-clock edge with `wr_rst` high sets the write position to column 0 and stores nothing. The next accepted write lands in column 0, and the contents of the banks are not disturbed.
- R2: A read-clock edge with `rd_rst` high sets the read position to column 0 and performs no read. `dly_oe` is 0 after that edge, and the next read returns column 0.
- R3: A write-clock edge with `wr_en` high and `wr_rst` low stores `wr_data` at the write position and then advances that position by one. With `wr_en` low, neither the stored data nor the position changes.
- R4: After a read edge, `dly1_q` equals the most recent word written at the column just read.
- R5: After a read edge, `dly2_q` equals the word written at that column one write before the most recent one, passed on by the cascade from the first bank into the second.
- R6: A read-clock edge with `rd_en` high and `rd_rst` low loads both taps from the same column in the same edge and advances the read position by one. With `rd_en` low, the read position holds.
- R7: `dly_oe` is 1 after a read-clock edge that performed a read, and 0 after any other read-clock edge. While it is 0, `dly1_q` and `dly2_q` are high impedance.
- R8: Both position counters go from column `LINE_LEN-1` back to column 0 on their next advance.
- R9: With the two clocks at different frequencies and the read position trailing the write position within a line, every read returns the values stored at that column at the time of the read.
- R10: When clear and enable are high on the same edge of a port, the clear takes precedence and no access takes place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous write position clear, active high |
| wr_en | input | 1 | Write accept for this edge |
| wr_data | input | PIX_W | Pixel to store |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous read position clear, active high |
| rd_en | input | 1 | Read accept for this edge |
| dly1_q | output | PIX_W | Pixel one line back (three-state) |
| dly2_q | output | PIX_W | Pixel two lines back (three-state) |
| dly_oe | output | 1 | High while the tap pins are driven |

## Verification
The hardest situation to reach from the ports is a read that runs while writes are in progress on a faster, unrelated clock. In that case the value seen depends on which side reached the column first. The bench runs the two clocks at 10 ns and 14 ns. It clears both positions, waits a few read cycles so the writer gets ahead, and then streams a full line on each side together. Because the read clock is slower, the read position keeps trailing. Separate passes cover other cases. They mix random enable gaps with clears that coincide with an enable, and they write past the end of the line so that both counters wrap.

// File: rtl/ldm_pkg.sv
package ldm_pkg;

    // Action a port takes on one of its clock edges.
    typedef enum logic [1:0] {
        PORT_IDLE  = 2'd0,
        PORT_CLEAR = 2'd1,
        PORT_STEP  = 2'd2
    } port_op_e;

    // Clear outranks an access on the same edge.
    function automatic port_op_e port_decode(input logic clr, input logic en);
        if (clr) return PORT_CLEAR;
        if (en)  return PORT_STEP;
        return PORT_IDLE;
    endfunction

    // Next column on a ring of 'len' positions.
    function automatic int unsigned ring_next(input int unsigned pos, input int unsigned len);
        if (pos + 1 >= len) return 0;
        return pos + 1;
    endfunction

endpackage

// File: rtl/ldm_port_ctl.sv
module ldm_port_ctl
    import ldm_pkg::*;
#(
    parameter int unsigned LINE_LEN = 1024,
    parameter int unsigned AW       = 10
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          en,
    output logic [AW-1:0] addr,
    output logic          step
);

    port_op_e op;

    always_comb begin
        op   = port_decode(clr, en);
        step = (op == PORT_STEP);
    end

    always_ff @(posedge clk) begin
        case (op)
            PORT_CLEAR: addr <= '0;
            PORT_STEP:  addr <= AW'(ring_next(32'(addr), LINE_LEN));
            default:    addr <= addr;
        endcase
    end

endmodule

// File: rtl/ldm_line_store.sv
module ldm_line_store #(
    parameter int unsigned LINE_LEN = 1024,
    parameter int unsigned PIX_W    = 8,
    parameter int unsigned AW       = 10,
    parameter int unsigned TAPS     = 2
) (
    input  logic                       wclk,
    input  logic                       we,
    input  logic [AW-1:0]              waddr,
    input  logic [PIX_W-1:0]           wdata,
    input  logic                       rclk,
    input  logic                       re,
    input  logic [AW-1:0]              raddr,
    output logic [TAPS-1:0][PIX_W-1:0] rword,
    output logic                       rvalid
);

    for (genvar t = 0; t < TAPS; t++) begin : g_bank
        logic [PIX_W-1:0] cells [LINE_LEN];
        logic [PIX_W-1:0] fill;
        logic [PIX_W-1:0] q;

        if (t == 0) begin : g_head
            assign fill = wdata;
        end else begin : g_link
            // word displaced from the bank one stage shallower
            assign fill = g_bank[t-1].cells[waddr];
        end

        always_ff @(posedge wclk) begin
            if (we) cells[waddr] <= fill;
        end

        always_ff @(posedge rclk) begin
            if (re) q <= cells[raddr];
        end

        assign rword[t] = q;
    end

    always_ff @(posedge rclk) begin
        rvalid <= re;
    end

endmodule

// File: rtl/ldm_line_delay.sv
module ldm_line_delay
    import ldm_pkg::*;
#(
    parameter int unsigned LINE_LEN = 1024,
    parameter int unsigned PIX_W    = 8
) (
    input  logic             wr_clk,
    input  logic             wr_rst,
    input  logic             wr_en,
    input  logic [PIX_W-1:0] wr_data,
    input  logic             rd_clk,
    input  logic             rd_rst,
    input  logic             rd_en,
    output logic [PIX_W-1:0] dly1_q,
    output logic [PIX_W-1:0] dly2_q,
    output logic             dly_oe
);

    localparam int unsigned AW   = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
    localparam int unsigned TAPS = 2;

    logic [AW-1:0]              wr_addr;
    logic [AW-1:0]              rd_addr;
    logic                       wr_step;
    logic                       rd_step;
    logic                       rd_oe;
    logic [TAPS-1:0][PIX_W-1:0] rd_word;

    ldm_port_ctl #(.LINE_LEN(LINE_LEN), .AW(AW)) u_wctl (
        .clk  (wr_clk),
        .clr  (wr_rst),
        .en   (wr_en),
        .addr (wr_addr),
        .step (wr_step)
    );

    ldm_port_ctl #(.LINE_LEN(LINE_LEN), .AW(AW)) u_rctl (
        .clk  (rd_clk),
        .clr  (rd_rst),
        .en   (rd_en),
        .addr (rd_addr),
        .step (rd_step)
    );

    ldm_line_store #(.LINE_LEN(LINE_LEN), .PIX_W(PIX_W), .AW(AW), .TAPS(TAPS)) u_store (
        .wclk   (wr_clk),
        .we     (wr_step),
        .waddr  (wr_addr),
        .wdata  (wr_data),
        .rclk   (rd_clk),
        .re     (rd_step),
        .raddr  (rd_addr),
        .rword  (rd_word),
        .rvalid (rd_oe)
    );

    assign dly1_q = rd_oe ? rd_word[0] : 'z;
    assign dly2_q = rd_oe ? rd_word[1] : 'z;
    assign dly_oe = rd_oe;

endmodule

// File: rtl/ldm_checker.sv
module ldm_checker #(
    parameter int unsigned LINE_LEN = 1024,
    parameter int unsigned AW       = 10
) (
    input logic          wclk,
    input logic          wrst,
    input logic          wen,
    input logic [AW-1:0] waddr,
    input logic          rclk,
    input logic          rrst,
    input logic          ren,
    input logic [AW-1:0] raddr,
    input logic          roe
);

    localparam logic [AW-1:0] LAST = AW'(LINE_LEN - 1);

    logic w_seen = 1'b0;
    logic r_seen = 1'b0;

    always_ff @(posedge wclk) if (wrst) w_seen <= 1'b1;
    always_ff @(posedge rclk) if (rrst) r_seen <= 1'b1;

    // R1
    wptr_clear_chk: assert property (@(posedge wclk) disable iff (!w_seen)
        wrst |=> (waddr == '0));

    // R3
    wptr_step_chk: assert property (@(posedge wclk) disable iff (!w_seen)
        (!wrst && wen) |=> (waddr == (($past(waddr) == LAST) ? '0 : $past(waddr) + 1'b1)));

    // R3
    wptr_hold_chk: assert property (@(posedge wclk) disable iff (!w_seen)
        (!wrst && !wen) |=> $stable(waddr));

    // R2
    rptr_clear_chk: assert property (@(posedge rclk) disable iff (!r_seen)
        rrst |=> (raddr == '0 && !roe));

    // R6
    rptr_hold_chk: assert property (@(posedge rclk) disable iff (!r_seen)
        (!rrst && !ren) |=> $stable(raddr));

    // R7
    oe_on_chk: assert property (@(posedge rclk) disable iff (!r_seen)
        (!rrst && ren) |=> roe);

    // R8
    rptr_wrap_chk: assert property (@(posedge rclk) disable iff (!r_seen)
        (!rrst && ren && raddr == LAST) |=> (raddr == '0));

endmodule

bind ldm_line_delay ldm_checker #(.LINE_LEN(LINE_LEN), .AW(AW)) u_chk (
    .wclk  (wr_clk),
    .wrst  (wr_rst),
    .wen   (wr_en),
    .waddr (wr_addr),
    .rclk  (rd_clk),
    .rrst  (rd_rst),
    .ren   (rd_en),
    .raddr (rd_addr),
    .roe   (rd_oe)
);

// File: tb/ldm_line_delay_tb.sv
module ldm_line_delay_tb_top;

    localparam int LEN = 12;

    logic       wr_clk = 1'b0;
    logic       rd_clk = 1'b0;
    logic       wr_rst = 1'b0;
    logic       wr_en  = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_rst = 1'b0;
    logic       rd_en  = 1'b0;
    wire  [7:0] dly1_q;
    wire  [7:0] dly2_q;
    wire        dly_oe;

    int nchk  = 0;
    int nfail = 0;

    int m0 [LEN];
    int m1 [LEN];
    int nw [LEN];
    int wp = 0;
    int rp = 0;

    string t_oe = "R7";
    string t_d1 = "R4";
    string t_d2 = "R5";

    always #5 wr_clk = ~wr_clk;
    always #7 rd_clk = ~rd_clk;

    ldm_line_delay #(.LINE_LEN(LEN), .PIX_W(8)) dut_i (
        .wr_clk  (wr_clk),
        .wr_rst  (wr_rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_clk  (rd_clk),
        .rd_rst  (rd_rst),
        .rd_en   (rd_en),
        .dly1_q  (dly1_q),
        .dly2_q  (dly2_q),
        .dly_oe  (dly_oe)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int nxt(input int p);
        return (p + 1 >= LEN) ? 0 : p + 1;
    endfunction

    // called at a falling write-clock edge; returns at the next one
    task automatic wr(input logic en, input logic rs, input logic [7:0] d);
        wr_en = en; wr_rst = rs; wr_data = d;
        @(posedge wr_clk);
        if (rs) wp = 0;
        else if (en) begin
            m1[wp] = m0[wp];
            m0[wp] = int'(d);
            nw[wp]++;
            wp = nxt(wp);
        end
        @(negedge wr_clk);
    endtask

    // called at a falling read-clock edge; checks after the rising edge
    task automatic rd(input logic en, input logic rs);
        bit eoe = 0, v1 = 0, v2 = 0;
        int e1 = 0, e2 = 0;
        rd_en = en; rd_rst = rs;
        @(posedge rd_clk);
        if (rs) rp = 0;
        else if (en) begin
            e1 = m0[rp]; e2 = m1[rp];
            v1 = nw[rp] >= 1; v2 = nw[rp] >= 2;
            rp = nxt(rp);
            eoe = 1;
        end
        @(negedge rd_clk);
        chk(dly_oe === eoe, t_oe, int'(dly_oe), int'(eoe));
        if (eoe && v1) chk(dly1_q === e1[7:0], t_d1, int'(dly1_q), e1);
        if (eoe && v2) chk(dly2_q === e2[7:0], t_d2, int'(dly2_q), e2);
    endtask

    task automatic wline(input int n, input int pct);
        int cnt = 0;
        while (cnt < n) begin
            logic en = ($urandom_range(0, 99) < pct);
            wr(en, 1'b0, 8'($urandom_range(0, 255)));
            if (en) cnt++;
        end
        wr(1'b0, 1'b0, 8'h00);
    endtask

    task automatic rline(input int n, input int pct);
        int cnt = 0;
        while (cnt < n) begin
            logic en = ($urandom_range(0, 99) < pct);
            rd(en, 1'b0);
            if (en) cnt++;
        end
        rd(1'b0, 1'b0);
    endtask

    initial begin
        #2000000;
        nfail++;
        $display("FAIL watchdog R9 act=timeout exp=done");
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7741));
        for (int i = 0; i < LEN; i++) begin m0[i] = 0; m1[i] = 0; nw[i] = 0; end

        // reset state: both pointers cleared, pins floating (R2)
        t_oe = "R2";
        fork
            begin @(negedge wr_clk); wr(1'b0, 1'b1, 8'h00); wr(1'b0, 1'b0, 8'h00); end
            begin @(negedge rd_clk); rd(1'b0, 1'b1); rd(1'b0, 1'b0); end
        join
        t_oe = "R7";

        // R3 R4 R5: three line passes with random enable gaps
        for (int p = 0; p < 3; p++) begin
            @(negedge wr_clk); wline(LEN, 70);
            @(negedge rd_clk); rd(1'b0, 1'b1); rline(LEN, 70);
        end

        // R8: both counters run past the last column without a clear
        t_d1 = "R8"; t_d2 = "R8";
        @(negedge wr_clk); wline(LEN + 3, 100);
        @(negedge rd_clk); rline(LEN + 3, 100);

        // R10 then R1: clear wins over enable; next write lands in column 0
        @(negedge wr_clk);
        wr(1'b1, 1'b0, 8'h11);
        wr(1'b1, 1'b0, 8'h22);
        wr(1'b1, 1'b1, 8'h5A);
        wr(1'b1, 1'b0, 8'hC3);
        wr(1'b0, 1'b0, 8'hEE);
        t_oe = "R10";
        @(negedge rd_clk); rd(1'b1, 1'b1);
        t_oe = "R7"; t_d1 = "R1"; t_d2 = "R5";
        rd(1'b1, 1'b0);
        chk(dly1_q === 8'hC3, "R1", int'(dly1_q), 'hC3);

        // R6: read position holds across idle edges
        t_d1 = "R6"; t_d2 = "R6";
        rd(1'b1, 1'b0);
        rd(1'b0, 1'b0); rd(1'b0, 1'b0); rd(1'b0, 1'b0);
        rd(1'b1, 1'b0);
        rd(1'b0, 1'b0);

        // R9: concurrent streaming, slower reader trailing the writer
        t_d1 = "R9"; t_d2 = "R9";
        fork
            begin
                @(negedge wr_clk); wr(1'b0, 1'b1, 8'h00);
                wline(LEN, 100);
            end
            begin
                @(negedge rd_clk); rd(1'b0, 1'b1);
                repeat (5) rd(1'b0, 1'b0);
                rline(LEN, 100);
            end
        join

        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

endmodule